// File: doc/BRIEF.md
# Load Latency Measurement Unit

This unit measures how long memory loads take so that a sampling record can carry the figure. A load gets a tag when it is first dispatched. From that point the tag's slot counts core clock cycles until the load's final data writeback arrives. A re-dispatch of a load that is still in flight does not restart its timer, so replay penalties are part of the measured figure. When the load retires, its frozen count goes to a last-latency register, but only if the load was a demand load. Prefetches, and loads that are flushed before they retire, leave that register untouched.

A counter bank raises a sampling trigger when a counter overflows. If latency capture is enabled in the same cycle, the unit emits a one-cycle sample pulse on the next cycle. The pulse carries the last-latency value that was held when the trigger was seen.

Top module: `load_latency_unit`

## Requirements
- R1: After reset, every slot is free and `last_valid`, `last_latency`, `smp_valid` and `smp_latency` are all zero.
- R2: A dispatch on a free tag starts that slot's count. The reported latency is the number of clock edges from the dispatch cycle to the writeback cycle, so a writeback in the cycle right after dispatch reports 1.
- R3: A dispatch on a tag whose slot is already busy (counting or written back) is a re-dispatch. It does not reset or change that slot's count.
- R4: A slot's count saturates at 2^CNT_W-1 and does not wrap.
- R5: Writeback freezes the slot's count. A retire any number of cycles later reports that frozen value.
- R6: A retire of a written-back demand load sets `last_latency` to its count on the next cycle, sets `last_valid`, and frees the tag. `last_latency` changes at no other time.
- R7: A retire of a written-back load that was dispatched with `disp_demand=0` (a prefetch) frees the tag and leaves `last_latency` and `last_valid` unchanged.
- R8: A flush clears the tagged slot and never updates `last_latency`. A flush in the same cycle as a retire of the same tag wins, so nothing is reported. A later dispatch on that tag starts a fresh count.
- R9: A writeback on a slot that is not counting is ignored. A retire on a slot that is not written back is ignored.
- R10: When `sample_trig` and `lat_capture_en` are both high, `smp_valid` is high for exactly the next cycle, and `smp_latency` then equals the `last_latency` held at the trigger cycle. A trigger with capture disabled gives no pulse.
- R11: Once set, `last_valid` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Load dispatch event |
| disp_tag | input | TAG_W | Tag of the dispatched load |
| disp_demand | input | 1 | 1 = demand load, 0 = prefetch |
| wb_valid | input | 1 | Final data writeback event |
| wb_tag | input | TAG_W | Tag being written back |
| ret_valid | input | 1 | Retire event |
| ret_tag | input | TAG_W | Tag being retired |
| flush_valid | input | 1 | Squash event |
| flush_tag | input | TAG_W | Tag being squashed |
| sample_trig | input | 1 | Overflow trigger from the counter bank |
| lat_capture_en | input | 1 | Latency capture enable for the trigger |
| last_valid | output | 1 | A qualifying load has been recorded |
| last_latency | output | CNT_W | Latency of the most recent retired demand load |
| smp_valid | output | 1 | One-cycle sample pulse |
| smp_latency | output | CNT_W | Latency delivered with the sample |

## Verification
The bench builds the unit with TAG_W=2 (four slots) and CNT_W=4, so a count saturates at 15. This makes the saturation boundary reachable with a 21-cycle load. The four slots also let the bench keep a demand load and a prefetch in flight together, and write them back out of order. With these sizes every slot state and every same-cycle conflict between a flush and a retire can be driven within a few hundred cycles.

// File: rtl/ldlat_pkg.sv
package ldlat_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_RUN  = 2'd1,
        SLOT_HELD = 2'd2
    } slot_state_e;
endpackage

// File: rtl/ldlat_slot.sv
module ldlat_slot
    import ldlat_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_demand,
    input  logic             wb,
    input  logic             retire,
    input  logic             flush,
    output logic             held,
    output logic             demand,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        slot_state_e      st;
        logic             dem;
        logic [CNT_W-1:0] cnt;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SLOT_FREE: begin
                if (start) begin
                    s_d.st  = SLOT_RUN;
                    s_d.dem = start_demand;
                    s_d.cnt = '0;
                end
            end
            SLOT_RUN: begin
                // re-dispatch lands here and is ignored: timer keeps going
                s_d.cnt = (s_q.cnt == CNT_MAX) ? CNT_MAX : s_q.cnt + 1'b1;
                if (wb) s_d.st = SLOT_HELD;
            end
            SLOT_HELD: begin
                if (retire) s_d.st = SLOT_FREE;
            end
            default: s_d.st = SLOT_FREE;
        endcase
        if (flush) begin
            s_d.st  = SLOT_FREE;
            s_d.dem = 1'b0;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SLOT_FREE, dem: 1'b0, cnt: '0};
        else        s_q <= s_d;
    end

    assign held   = (s_q.st == SLOT_HELD);
    assign demand = s_q.dem;
    assign count  = s_q.cnt;
endmodule

// File: rtl/ldlat_report.sv
module ldlat_report #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ret_fire,
    input  logic             ret_demand,
    input  logic [CNT_W-1:0] ret_count,
    input  logic             trig,
    input  logic             cap_en,
    output logic             last_valid,
    output logic [CNT_W-1:0] last_lat,
    output logic             smp_valid,
    output logic [CNT_W-1:0] smp_lat
);
    typedef struct packed {
        logic             lv;
        logic [CNT_W-1:0] ll;
        logic             sv;
        logic [CNT_W-1:0] sl;
    } rep_t;

    rep_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.sv = trig && cap_en;
        if (trig && cap_en) r_d.sl = r_q.ll;
        if (ret_fire && ret_demand) begin
            r_d.ll = ret_count;
            r_d.lv = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign last_valid = r_q.lv;
    assign last_lat   = r_q.ll;
    assign smp_valid  = r_q.sv;
    assign smp_lat    = r_q.sl;
endmodule

// File: rtl/load_latency_unit.sv
module load_latency_unit #(
    parameter int TAG_W = 3,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_valid,
    input  logic [TAG_W-1:0] disp_tag,
    input  logic             disp_demand,
    input  logic             wb_valid,
    input  logic [TAG_W-1:0] wb_tag,
    input  logic             ret_valid,
    input  logic [TAG_W-1:0] ret_tag,
    input  logic             flush_valid,
    input  logic [TAG_W-1:0] flush_tag,
    input  logic             sample_trig,
    input  logic             lat_capture_en,
    output logic             last_valid,
    output logic [CNT_W-1:0] last_latency,
    output logic             smp_valid,
    output logic [CNT_W-1:0] smp_latency
);
    localparam int NUM_TAGS = 1 << TAG_W;

    logic             slot_held [NUM_TAGS];
    logic             slot_dem  [NUM_TAGS];
    logic [CNT_W-1:0] slot_cnt  [NUM_TAGS];

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
        ldlat_slot #(.CNT_W(CNT_W)) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .start        (disp_valid  && (disp_tag  == TAG_W'(g))),
            .start_demand (disp_demand),
            .wb           (wb_valid    && (wb_tag    == TAG_W'(g))),
            .retire       (ret_valid   && (ret_tag   == TAG_W'(g))),
            .flush        (flush_valid && (flush_tag == TAG_W'(g))),
            .held         (slot_held[g]),
            .demand       (slot_dem[g]),
            .count        (slot_cnt[g])
        );
    end

    logic ret_fire;
    assign ret_fire = ret_valid && slot_held[ret_tag]
                      && !(flush_valid && (flush_tag == ret_tag));

    ldlat_report #(.CNT_W(CNT_W)) u_report (
        .clk        (clk),
        .rst_n      (rst_n),
        .ret_fire   (ret_fire),
        .ret_demand (slot_dem[ret_tag]),
        .ret_count  (slot_cnt[ret_tag]),
        .trig       (sample_trig),
        .cap_en     (lat_capture_en),
        .last_valid (last_valid),
        .last_lat   (last_latency),
        .smp_valid  (smp_valid),
        .smp_lat    (smp_latency)
    );
endmodule

// File: rtl/ldlat_chk.sv
module ldlat_chk #(
    parameter int TAG_W = 3,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ret_valid,
    input logic [TAG_W-1:0] ret_tag,
    input logic             flush_valid,
    input logic [TAG_W-1:0] flush_tag,
    input logic             sample_trig,
    input logic             lat_capture_en,
    input logic             last_valid,
    input logic [CNT_W-1:0] last_latency,
    input logic             smp_valid,
    input logic [CNT_W-1:0] smp_latency
);
    assert_smp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_trig && lat_capture_en) |=> smp_valid);

    assert_smp_needs_trig_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(sample_trig && lat_capture_en)) |=> !smp_valid);

    assert_smp_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_trig && lat_capture_en) |=> (smp_latency == $past(last_latency)));

    assert_valid_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        last_valid |=> last_valid);

    assert_hold_without_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_valid |=> ($stable(last_latency) && $stable(last_valid)));

    assert_flush_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && flush_valid && (flush_tag == ret_tag)) |=>
            ($stable(last_latency) && $stable(last_valid)));
endmodule

bind load_latency_unit ldlat_chk #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ret_valid      (ret_valid),
    .ret_tag        (ret_tag),
    .flush_valid    (flush_valid),
    .flush_tag      (flush_tag),
    .sample_trig    (sample_trig),
    .lat_capture_en (lat_capture_en),
    .last_valid     (last_valid),
    .last_latency   (last_latency),
    .smp_valid      (smp_valid),
    .smp_latency    (smp_latency)
);

// File: tb/load_latency_unit_test.sv
module load_latency_unit_test;
    localparam int TAG_W = 2;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             disp_valid = 0, disp_demand = 0;
    logic [TAG_W-1:0] disp_tag = '0;
    logic             wb_valid = 0;
    logic [TAG_W-1:0] wb_tag = '0;
    logic             ret_valid = 0;
    logic [TAG_W-1:0] ret_tag = '0;
    logic             flush_valid = 0;
    logic [TAG_W-1:0] flush_tag = '0;
    logic             sample_trig = 0, lat_capture_en = 0;
    logic             last_valid, smp_valid;
    logic [CNT_W-1:0] last_latency, smp_latency;

    int checks = 0;
    int failures = 0;
    int exp_q[$];

    always #10 clk = ~clk;

    load_latency_unit #(.TAG_W(TAG_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_demand(disp_demand),
        .wb_valid(wb_valid), .wb_tag(wb_tag),
        .ret_valid(ret_valid), .ret_tag(ret_tag),
        .flush_valid(flush_valid), .flush_tag(flush_tag),
        .sample_trig(sample_trig), .lat_capture_en(lat_capture_en),
        .last_valid(last_valid), .last_latency(last_latency),
        .smp_valid(smp_valid), .smp_latency(smp_latency)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        disp_valid = 0; wb_valid = 0; ret_valid = 0; flush_valid = 0;
        sample_trig = 0; lat_capture_en = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic disp(input int tag, input logic dem);
        disp_valid = 1; disp_tag = TAG_W'(tag); disp_demand = dem; tick();
    endtask

    task automatic wb(input int tag);
        wb_valid = 1; wb_tag = TAG_W'(tag); tick();
    endtask

    task automatic ret(input int tag);
        ret_valid = 1; ret_tag = TAG_W'(tag); tick();
    endtask

    task automatic sample(input int exp);
        exp_q.push_back(exp);
        sample_trig = 1; lat_capture_en = 1; tick();
    endtask

    // monitor: pops expected sample latencies as pulses appear
    always @(negedge clk) begin
        if (rst_n && smp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R10 unexpected sample pulse actual=%0d expected=none", smp_latency);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (int'(smp_latency) != e) begin
                    failures++;
                    $display("FAIL R10 sample latency actual=%0d expected=%0d", smp_latency, e);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 last_valid", last_valid, 0);
        chk("R1 last_latency", last_latency, 0);
        chk("R1 smp_valid", smp_valid, 0);
        chk("R1 smp_latency", smp_latency, 0);
        sample(0);                                   // R10 before any retire

        // R2 basic latency: dispatch, two idle, writeback -> 3
        disp(0, 1); idle(2); wb(0); ret(0);
        chk("R2 R6 last_latency", last_latency, 3);
        chk("R6 R11 last_valid", last_valid, 1);
        sample(3);

        // R3 re-dispatch keeps counting -> 4
        disp(1, 1); idle(1); disp(1, 1); idle(1); wb(1); ret(1);
        chk("R3 re-dispatch latency", last_latency, 4);

        // R7 prefetch retire ignored; out-of-order writeback
        disp(2, 1); disp(3, 0); wb(3); wb(2); ret(3);
        chk("R7 prefetch no update", last_latency, 4);
        ret(2);
        chk("R2 interleaved latency", last_latency, 3);

        // R4 saturation at 15
        disp(0, 1); idle(20); wb(0); ret(0);
        chk("R4 saturated latency", last_latency, 15);
        sample(15);

        // R5 frozen at writeback
        disp(1, 1); idle(1); wb(1); idle(5); ret(1);
        chk("R5 frozen latency", last_latency, 2);

        // R8 flush clears, later restart
        disp(2, 1); wb(2);
        flush_valid = 1; flush_tag = 2; tick();
        ret(2);
        chk("R8 flush no update", last_latency, 2);
        disp(2, 1); idle(3); wb(2); ret(2);
        chk("R8 fresh count after flush", last_latency, 4);

        // R9 ignored writeback / retire
        wb(3); ret(3);
        chk("R9 retire of free tag", last_latency, 4);
        disp(3, 1); ret(3);
        chk("R9 retire while counting", last_latency, 4);
        idle(1); wb(3); ret(3);
        chk("R9 later true latency", last_latency, 3);

        // R8 flush and retire same cycle
        disp(0, 1); wb(0);
        ret_valid = 1; ret_tag = 0; flush_valid = 1; flush_tag = 0; tick();
        chk("R8 flush beats retire", last_latency, 3);
        ret(0);
        chk("R8 slot freed by flush", last_latency, 3);

        // R10 trigger without capture enable
        sample_trig = 1; lat_capture_en = 0; tick();
        chk("R10 no pulse when disabled", smp_valid, 0);
        sample(3);
        tick();
        chk("R10 pulse lasts one cycle", smp_valid, 0);
        chk("R11 last_valid sticky", last_valid, 1);
        chk("R10 all samples seen", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule